// File: doc/BRIEF.md
# APB4 Requester Transfer Sequencer

This block is the requester side of an APB4 link. It accepts one command at a time over a valid/ready handshake. A command carries an address, a direction flag, write data, byte-lane enables and a three-bit protection attribute. The block drives that command onto a single subordinate select as a two-phase transfer: one setup cycle, followed by an access cycle that stretches for as long as the subordinate holds PREADY low.

When the subordinate signals ready, the transfer is complete. In the next cycle the block presents a one-cycle response pulse, which carries the read data and an error flag taken from PSLVERR.

A one-entry holding register lets the next command wait while a transfer is in flight. A command that is available at the completion edge starts its setup cycle immediately. If no command is available, the bus returns to idle. Transfers never overlap.

Top module: `apb_txn_sequencer`

## Requirements
- R1: While reset is held and directly after it, `psel`, `penable` and `resp_valid` are low and `cmd_ready` is high.
- R2: A command presented with `cmd_valid` high while the bus is idle is accepted at that clock edge. The next cycle is a setup cycle: `psel`=1 and `penable`=0. In that cycle `paddr`, `pwrite`, `pwdata` and `pprot` equal the command's fields. Setup lasts exactly one cycle and is followed by an access cycle (`penable`=1).
- R3: While `psel`=1, `penable`=1 and `pready`=0, the access cycle repeats. Address, direction, write data, strobes and protection stay unchanged, and no response is given.
- R4: A transfer completes at the edge where `psel`, `penable` and `pready` are all high. In the following cycle `resp_valid` is high for exactly one cycle. `resp_err` then equals `pslverr` as sampled at that completion edge. `pslverr` values seen during wait cycles have no effect.
- R5: For a read, `resp_rdata` equals `prdata` as sampled at the completion edge. For a write, `resp_rdata` is zero.
- R6: `pstrb` equals the command's strobes on a write. It is all zeros on a read, whatever strobes the command carried.
- R7: `pprot` is carried unchanged from the command and is valid from the setup cycle onward. Bit 0 set means a privileged access. Bit 1 set means a non-secure access. Bit 2 set means an instruction access.
- R8: At a completion edge, if a command is waiting in the holding register or is presented on the command port in that same cycle, the next cycle is that command's setup cycle (`psel`=1, `penable`=0). Otherwise the next cycle is idle with `psel`=0 and `penable`=0.
- R9: A command accepted during a transfer is held unchanged until its own setup cycle. `cmd_ready` is low while it waits.
- R10: `pready` is ignored in the setup cycle. A high `pready` there neither skips the access cycle nor produces a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Transfer address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_strb | input | DATA_W/8 | Byte-lane enables for writes |
| cmd_prot | input | 3 | Protection attribute |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Subordinate error status |
| resp_rdata | output | DATA_W | Read data (zero for writes) |
| psel | output | 1 | Subordinate select |
| penable | output | 1 | Access phase marker |
| paddr | output | ADDR_W | Bus address |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DATA_W | Bus write data |
| pstrb | output | DATA_W/8 | Bus byte strobes |
| pprot | output | 3 | Bus protection attribute |
| pready | input | 1 | Subordinate ready |
| prdata | input | DATA_W | Subordinate read data |
| pslverr | input | 1 | Subordinate error |

## Verification
The interesting collision is a transfer completing in the same cycle that a new command is taken. The response pulse of the finished transfer then coincides with the setup cycle of the next one.

The bench provokes this in two ways. In the first, a command is already parked in the holding register when the subordinate raises ready. In the second, a fresh command is presented on the port in exactly the completion cycle while the holding register is empty.

In both cases, the cycle after the edge is judged on several points at once. It must show the old transfer's response (data and error). It must show the new command's setup with the new address and direction. It must show `cmd_ready` reflecting the holding register.

// File: rtl/apbseq_pkg.sv
package apbseq_pkg;

    // Protection attribute width fixed by the bus protocol
    localparam int PROT_W = 3;

    // Transfer phases
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_e;

endpackage

// File: rtl/apbseq_cmd_slot.sv
// One-entry command holding register with a pass-through path.
module apbseq_cmd_slot #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic                          in_write,
    input  logic [ADDR_W-1:0]             in_addr,
    input  logic [DATA_W-1:0]             in_wdata,
    input  logic [DATA_W/8-1:0]           in_strb,
    input  logic [apbseq_pkg::PROT_W-1:0] in_prot,
    input  logic                          take_i,
    output logic                          head_valid_o,
    output logic                          head_write_o,
    output logic [ADDR_W-1:0]             head_addr_o,
    output logic [DATA_W-1:0]             head_wdata_o,
    output logic [DATA_W/8-1:0]           head_strb_o,
    output logic [apbseq_pkg::PROT_W-1:0] head_prot_o
);
    localparam int STRB_W = DATA_W / 8;

    typedef struct packed {
        logic                          write;
        logic [ADDR_W-1:0]             addr;
        logic [DATA_W-1:0]             wdata;
        logic [STRB_W-1:0]             strb;
        logic [apbseq_pkg::PROT_W-1:0] prot;
    } cmd_t;

    typedef struct packed {
        logic full;
        cmd_t cmd;
    } slot_t;

    slot_t slot_d, slot_q;
    cmd_t  in_cmd, head;

    always_comb begin
        in_cmd = '{write: in_write, addr: in_addr, wdata: in_wdata,
                   strb: in_strb, prot: in_prot};
        head   = slot_q.full ? slot_q.cmd : in_cmd;
        slot_d = slot_q;
        if (take_i && slot_q.full) begin
            // parked command moves onto the bus
            slot_d.full = 1'b0;
        end else if (!take_i && in_valid && !slot_q.full) begin
            // park the new command until the bus frees up
            slot_d.full = 1'b1;
            slot_d.cmd  = in_cmd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign in_ready     = !slot_q.full;
    assign head_valid_o = slot_q.full || in_valid;
    assign head_write_o = head.write;
    assign head_addr_o  = head.addr;
    assign head_wdata_o = head.wdata;
    assign head_strb_o  = head.strb;
    assign head_prot_o  = head.prot;

    // R9: a parked command is not altered while it waits
    assert_parked_cmd_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q.full && !take_i |=> slot_q.full && $stable(slot_q.cmd));

endmodule

// File: rtl/apbseq_phase_fsm.sv
// Idle / setup / access sequencer driving the bus-side registers.
module apbseq_phase_fsm #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          head_valid_i,
    input  logic                          head_write_i,
    input  logic [ADDR_W-1:0]             head_addr_i,
    input  logic [DATA_W-1:0]             head_wdata_i,
    input  logic [DATA_W/8-1:0]           head_strb_i,
    input  logic [apbseq_pkg::PROT_W-1:0] head_prot_i,
    output logic                          take_o,
    output logic                          done_o,
    input  logic                          pready,
    output logic                          psel,
    output logic                          penable,
    output logic [ADDR_W-1:0]             paddr,
    output logic                          pwrite,
    output logic [DATA_W-1:0]             pwdata,
    output logic [DATA_W/8-1:0]           pstrb,
    output logic [apbseq_pkg::PROT_W-1:0] pprot
);
    import apbseq_pkg::*;

    localparam int STRB_W = DATA_W / 8;

    typedef struct packed {
        phase_e                ph;
        logic                  write;
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     wdata;
        logic [STRB_W-1:0]     strb;
        logic [PROT_W-1:0]     prot;
    } bus_t;

    bus_t bus_d, bus_q;
    logic finish;
    logic take;

    always_comb begin
        finish = (bus_q.ph == PH_ACCESS) && pready;
        take   = (bus_q.ph == PH_IDLE) || finish;
        bus_d  = bus_q;
        unique case (bus_q.ph)
            PH_SETUP:  bus_d.ph = PH_ACCESS;
            PH_ACCESS: if (pready) bus_d.ph = PH_IDLE;
            default:   bus_d.ph = PH_IDLE;
        endcase
        if (take && head_valid_i) begin
            bus_d.ph    = PH_SETUP;
            bus_d.write = head_write_i;
            bus_d.addr  = head_addr_i;
            bus_d.wdata = head_wdata_i;
            bus_d.strb  = head_write_i ? head_strb_i : '0;
            bus_d.prot  = head_prot_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            bus_q <= bus_d;
        end
    end

    assign take_o  = take;
    assign done_o  = finish;
    assign psel    = (bus_q.ph != PH_IDLE);
    assign penable = (bus_q.ph == PH_ACCESS);
    assign paddr   = bus_q.addr;
    assign pwrite  = bus_q.write;
    assign pwdata  = bus_q.wdata;
    assign pstrb   = bus_q.strb;
    assign pprot   = bus_q.prot;

    // R2 / R10: setup is one cycle and always leads to access
    assert_setup_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !penable |=> psel && penable);

    // R3: wait states keep every bus field steady
    assert_access_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && !pready |=> psel && penable && $stable(paddr)
            && $stable(pwrite) && $stable(pwdata) && $stable(pstrb) && $stable(pprot));

    // R6: no byte lanes are flagged during a read
    assert_read_strobe_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        psel && !pwrite |-> pstrb == '0);

    // R8: with nothing waiting, completion returns the bus to idle
    assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        psel && penable && pready && !head_valid_i |=> !psel && !penable);

    // R8: enable is never raised without select
    assert_enable_has_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> psel);

endmodule

// File: rtl/apbseq_resp_capture.sv
// Completion-edge capture of read data and error status.
module apbseq_resp_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              is_write_i,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pslverr,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [DATA_W-1:0] resp_rdata
);
    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } resp_t;

    resp_t resp_d, resp_q;

    always_comb begin
        resp_d       = resp_q;
        resp_d.valid = done_i;
        if (done_i) begin
            resp_d.err   = pslverr;
            resp_d.rdata = is_write_i ? '0 : prdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign resp_valid = resp_q.valid;
    assign resp_err   = resp_q.err;
    assign resp_rdata = resp_q.rdata;

    // R4: a response is a single-cycle pulse
    assert_resp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R4: error flag follows the completion-edge sample
    assert_err_sampled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> resp_valid && (resp_err == $past(pslverr)));

    // R5: writes never return data
    assert_write_rdata_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && is_write_i |=> resp_rdata == '0);

endmodule

// File: rtl/apb_txn_sequencer.sv
// APB4 requester: command in, two-phase transfer out, response back.
module apb_txn_sequencer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    output logic                          cmd_ready,
    input  logic                          cmd_write,
    input  logic [ADDR_W-1:0]             cmd_addr,
    input  logic [DATA_W-1:0]             cmd_wdata,
    input  logic [DATA_W/8-1:0]           cmd_strb,
    input  logic [apbseq_pkg::PROT_W-1:0] cmd_prot,
    output logic                          resp_valid,
    output logic                          resp_err,
    output logic [DATA_W-1:0]             resp_rdata,
    output logic                          psel,
    output logic                          penable,
    output logic [ADDR_W-1:0]             paddr,
    output logic                          pwrite,
    output logic [DATA_W-1:0]             pwdata,
    output logic [DATA_W/8-1:0]           pstrb,
    output logic [apbseq_pkg::PROT_W-1:0] pprot,
    input  logic                          pready,
    input  logic [DATA_W-1:0]             prdata,
    input  logic                          pslverr
);
    localparam int STRB_W = DATA_W / 8;

    logic                          head_valid;
    logic                          head_write;
    logic [ADDR_W-1:0]             head_addr;
    logic [DATA_W-1:0]             head_wdata;
    logic [STRB_W-1:0]             head_strb;
    logic [apbseq_pkg::PROT_W-1:0] head_prot;
    logic                          take;
    logic                          done;

    apbseq_cmd_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (cmd_valid),
        .in_ready     (cmd_ready),
        .in_write     (cmd_write),
        .in_addr      (cmd_addr),
        .in_wdata     (cmd_wdata),
        .in_strb      (cmd_strb),
        .in_prot      (cmd_prot),
        .take_i       (take),
        .head_valid_o (head_valid),
        .head_write_o (head_write),
        .head_addr_o  (head_addr),
        .head_wdata_o (head_wdata),
        .head_strb_o  (head_strb),
        .head_prot_o  (head_prot)
    );

    apbseq_phase_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_valid_i (head_valid),
        .head_write_i (head_write),
        .head_addr_i  (head_addr),
        .head_wdata_i (head_wdata),
        .head_strb_i  (head_strb),
        .head_prot_i  (head_prot),
        .take_o       (take),
        .done_o       (done),
        .pready       (pready),
        .psel         (psel),
        .penable      (penable),
        .paddr        (paddr),
        .pwrite       (pwrite),
        .pwdata       (pwdata),
        .pstrb        (pstrb),
        .pprot        (pprot)
    );

    apbseq_resp_capture #(.DATA_W(DATA_W)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done),
        .is_write_i (pwrite),
        .prdata     (prdata),
        .pslverr    (pslverr),
        .resp_valid (resp_valid),
        .resp_err   (resp_err),
        .resp_rdata (resp_rdata)
    );

    // R9: the port refuses commands only while one is parked
    assert_ready_vs_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !psel |-> cmd_ready);

endmodule

// File: tb/sim_apb_txn_sequencer.sv
module sim_apb_txn_sequencer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_ready, cmd_write;
    logic [15:0] cmd_addr;
    logic [31:0] cmd_wdata;
    logic [3:0]  cmd_strb;
    logic [2:0]  cmd_prot;
    logic        resp_valid, resp_err;
    logic [31:0] resp_rdata;
    logic        psel, penable, pwrite;
    logic [15:0] paddr;
    logic [31:0] pwdata;
    logic [3:0]  pstrb;
    logic [2:0]  pprot;
    logic        pready, pslverr;
    logic [31:0] prdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    apb_txn_sequencer u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_strb(cmd_strb), .cmd_prot(cmd_prot),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite),
        .pwdata(pwdata), .pstrb(pstrb), .pprot(pprot),
        .pready(pready), .prdata(prdata), .pslverr(pslverr)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [3:0]  strb;
        logic [2:0]  prot;
        logic [3:0]  waits;
        logic        err;
        logic [31:0] rdata;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h0040, 32'hA5A5_1234, 4'b0101, 3'b001, 4'd0, 1'b0, 32'h1111_2222},
        '{1'b0, 16'h0104, 32'h0000_0000, 4'b0000, 3'b000, 4'd0, 1'b0, 32'hDEAD_BEEF},
        '{1'b1, 16'h0208, 32'h0BAD_F00D, 4'b1111, 3'b010, 4'd3, 1'b1, 32'h3333_4444},
        '{1'b0, 16'h030C, 32'hFFFF_FFFF, 4'b1111, 3'b100, 4'd2, 1'b0, 32'hCAFE_0001},
        '{1'b0, 16'h0410, 32'h0000_0000, 4'b0011, 3'b111, 4'd1, 1'b1, 32'h5555_AAAA},
        '{1'b1, 16'hFFFC, 32'h8000_0001, 4'b1000, 3'b110, 4'd0, 1'b0, 32'h7777_7777}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic offer(input logic wr, input logic [15:0] a, input logic [31:0] d,
                         input logic [3:0] s, input logic [2:0] p);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a;
        cmd_wdata = d; cmd_strb = s; cmd_prot = p;
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        offer(v.wr, v.addr, v.wdata, v.strb, v.prot);
        pready = 1'b1; pslverr = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2 setup psel", psel, 1);
        chk("R2 setup penable", penable, 0);
        chk("R2 paddr", paddr, v.addr);
        chk("R2 pwrite", pwrite, v.wr);
        if (v.wr) chk("R2 pwdata", pwdata, v.wdata);
        chk("R6 pstrb", pstrb, v.wr ? v.strb : 4'b0);
        chk("R7 pprot", pprot, v.prot);
        @(negedge clk);  // pready was high during setup
        chk("R10 access follows setup", {psel, penable}, 2'b11);
        chk("R10 no response from setup", resp_valid, 0);
        for (int i = 0; i < v.waits; i++) begin
            pready = 1'b0; pslverr = 1'b1; prdata = 32'hBAD0_0000 | i;
            @(negedge clk);
            chk("R3 wait keeps access", {psel, penable}, 2'b11);
            chk("R3 wait keeps paddr", paddr, v.addr);
            chk("R3 wait keeps pprot", pprot, v.prot);
            chk("R3 no response in wait", resp_valid, 0);
        end
        pready = 1'b1; pslverr = v.err; prdata = v.rdata;
        @(negedge clk);
        pslverr = 1'b0;
        chk("R4 resp_valid", resp_valid, 1);
        chk("R4 resp_err", resp_err, v.err);
        chk("R5 resp_rdata", resp_rdata, v.wr ? 32'h0 : v.rdata);
        chk("R8 idle after done", {psel, penable}, 2'b00);
        @(negedge clk);
        chk("R4 single pulse", resp_valid, 0);
    endtask

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0;
        cmd_wdata = '0; cmd_strb = '0; cmd_prot = '0;
        pready = 1'b1; pslverr = 1'b0; prdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 psel in reset", psel, 0);
        chk("R1 penable in reset", penable, 0);
        chk("R1 resp_valid in reset", resp_valid, 0);
        chk("R1 cmd_ready in reset", cmd_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {psel, penable, resp_valid, cmd_ready}, 4'b0001);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // Back-to-back through the holding register: A (write), B (read), C (write)
        @(negedge clk);
        offer(1'b1, 16'h0A00, 32'hAAAA_0000, 4'hF, 3'b000);
        pready = 1'b1;
        @(negedge clk);
        chk("R2 setup A", {psel, penable, paddr}, {2'b10, 16'h0A00});
        offer(1'b0, 16'h0B00, 32'h0, 4'hF, 3'b011);
        @(negedge clk);
        chk("R9 cmd_ready low while parked", cmd_ready, 0);
        chk("R3 access A", {psel, penable}, 2'b11);
        offer(1'b1, 16'h0C00, 32'hCCCC_0000, 4'b0110, 3'b101);
        pready = 1'b0;
        @(negedge clk);
        chk("R3 A still waiting", {penable, paddr}, {1'b1, 16'h0A00});
        pready = 1'b1;
        @(negedge clk);
        chk("R4 response A", resp_valid, 1);
        chk("R8 B setup right after A", {psel, penable, paddr}, {2'b10, 16'h0B00});
        chk("R9 parked B intact", {pwrite, pprot, pstrb}, {1'b0, 3'b011, 4'h0});
        chk("R9 cmd_ready back high", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 C parked", cmd_ready, 0);
        chk("R3 access B", {penable, paddr}, {1'b1, 16'h0B00});
        prdata = 32'h0B0B_1234;
        @(negedge clk);
        chk("R5 B read data", resp_rdata, 32'h0B0B_1234);
        chk("R8 C setup right after B", {psel, penable, paddr}, {2'b10, 16'h0C00});
        chk("R6 C strobes", pstrb, 4'b0110);
        @(negedge clk);
        chk("R3 access C", {psel, penable}, 2'b11);
        @(negedge clk);
        chk("R4 response C", {resp_valid, resp_rdata}, {1'b1, 32'h0});
        chk("R8 idle after C", {psel, penable}, 2'b00);

        // Command offered exactly in the completion cycle: D (read), E (write)
        @(negedge clk);
        offer(1'b0, 16'h0D00, 32'h0, 4'h0, 3'b001);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2 setup D", {psel, penable, paddr}, {2'b10, 16'h0D00});
        @(negedge clk);
        chk("R8 ready while D in access", cmd_ready, 1);
        offer(1'b1, 16'h0E00, 32'hEEEE_5678, 4'b0001, 3'b010);
        prdata = 32'h0D0D_9999; pready = 1'b1; pslverr = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; pslverr = 1'b0;
        chk("R4 response D with error", {resp_valid, resp_err}, 2'b11);
        chk("R5 D read data", resp_rdata, 32'h0D0D_9999);
        chk("R8 E setup at D completion", {psel, penable, paddr, pwrite}, {2'b10, 16'h0E00, 1'b1});
        chk("R7 E pprot", pprot, 3'b010);
        @(negedge clk);
        chk("R3 access E", {psel, penable}, 2'b11);
        @(negedge clk);
        chk("R4 response E", {resp_valid, resp_err, resp_rdata}, {2'b10, 32'h0});
        chk("R8 idle after E", {psel, penable}, 2'b00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule